// File: doc/BRIEF.md
# DMA Block Size and Completion Tracker

This block keeps the upper control word of one DMA channel and follows one block of a transfer from start to completion. The word packs four fields: arbitration class, arbitration weight, a completion flag and the block size in bytes. Software can write the word while the channel is stopped. A linked-list descriptor can also load it between blocks.

While a block runs, the block counts the bytes for which read commands have gone out to the source. Reading the size field then returns that running count instead of the programmed size. When the count reaches the programmed size, the block raises a completion pulse. If status write-back is on, it also issues a write-back request that carries the control word with its completion flag set.

A descriptor that arrives with its completion flag already set is refused and the channel halts. A descriptor that tries to change the class or the weight is flagged as a configuration error and leaves the arbitration settings untouched. The memory traffic itself happens elsewhere; this block only tracks and reports.

Top module: `dma_blk_tracker`

## Requirements
- R1: After reset the read-back word is 0, and `blk_done`, `wb_req`, `desc_rej` and `cfg_err` are all low.
- R2: A register write while `ch_enable` is low and the channel is idle or halted loads all four fields. Class is bits 31:29, weight is bits 28:18, the flag is bit 17 and size is bits 16:0. The write also clears `desc_rej` and `cfg_err`. A register write while the channel is enabled is ignored.
- R3: While a block runs or has just ended, bits 16:0 of the read-back word show the bytes issued so far in this block. The count saturates at the programmed size.
- R4: While the channel is disabled, and while it is halted, bits 16:0 of the read-back word show the programmed size.
- R5: A block completes when the issued count equals the programmed size. Completion gives a one-cycle `blk_done` pulse. A size of 0 completes with no reads, and `blk_done` is seen two clock edges after `ch_enable` rises.
- R6: With `wb_enable` high, completion also gives a one-cycle `wb_req` pulse. `wb_data` then holds the current class, weight and size with bit 17 forced to 1. With `wb_enable` low, no `wb_req` is raised.
- R7: A descriptor whose bit 17 is 1 is not loaded. It sets `desc_rej`, and the channel halts. While halted, issue strobes are not counted and no completion occurs. Only a register write with `ch_enable` low leaves the halt.
- R8: An accepted descriptor whose class or weight differs from the current value sets `cfg_err`. The class and weight stay as they were, and the size and flag still load.
- R9: A descriptor whose bit 17 is 0, loaded after a block end while enabled, starts a new block with the issued count cleared to 0.
- R10: Read-issue strobes are not counted while no block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 1 | Channel enable level |
| wb_enable | input | 1 | Status write-back enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write word |
| reg_rd_data | output | 32 | Registered read-back word |
| desc_ld_en | input | 1 | Descriptor load strobe |
| desc_ld_data | input | 32 | Control word fetched from the descriptor |
| rd_issue_vld | input | 1 | A read command was sent to the source |
| rd_issue_bytes | input | 12 | Bytes requested by that read command |
| blk_done | output | 1 | One-cycle block completion pulse |
| wb_req | output | 1 | One-cycle write-back request |
| wb_data | output | 32 | Control word to write back, flag set |
| desc_rej | output | 1 | Sticky: a descriptor was refused, channel halted |
| cfg_err | output | 1 | Sticky: descriptor class or weight mismatch |

## Verification
Inputs are driven on the falling edge. The state and counter registers take them on the next rising edge, and the read-back register copies them one edge later. Each read-back check is therefore sampled on the falling edge after the second rising edge.

Completion takes the same two edges after the last counted issue: one edge updates the count and the next registers `blk_done`, `wb_req` and `wb_data`. The bench samples these pulses in that window and checks one cycle later that they have dropped.

Error flags and descriptor starts are checked after the same two edges. For a zero-size block, `blk_done` is checked low after the first edge that follows enable and high after the second.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_BLKEND = 2'd2,
    ST_HALT   = 2'd3
  } dbt_state_e;
endpackage

// File: rtl/dbt_cfg_regs.sv
module dbt_cfg_regs #(
  parameter int CLASS_W  = 3,
  parameter int WEIGHT_W = 11,
  parameter int SIZE_W   = 17,
  localparam int WORD_W  = CLASS_W + WEIGHT_W + 1 + SIZE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_wr_i,
  input  logic                desc_take_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [CLASS_W-1:0]  cls_o,
  output logic [WEIGHT_W-1:0] wgt_o,
  output logic                done_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic                cfg_err_o
);
  localparam int WGT_LSB = SIZE_W + 1;
  localparam int CLS_LSB = WGT_LSB + WEIGHT_W;

  logic [CLASS_W-1:0]  cls_q, in_cls;
  logic [WEIGHT_W-1:0] wgt_q, in_wgt;
  logic [SIZE_W-1:0]   size_q, in_size;
  logic                done_q, in_done, err_q, arb_differs;

  assign in_size     = word_i[SIZE_W-1:0];
  assign in_done     = word_i[SIZE_W];
  assign in_wgt      = word_i[WGT_LSB +: WEIGHT_W];
  assign in_cls      = word_i[CLS_LSB +: CLASS_W];
  assign arb_differs = (in_cls != cls_q) || (in_wgt != wgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q  <= '0;
      wgt_q  <= '0;
      done_q <= 1'b0;
      size_q <= '0;
      err_q  <= 1'b0;
    end else if (sw_wr_i) begin
      cls_q  <= in_cls;
      wgt_q  <= in_wgt;
      done_q <= in_done;
      size_q <= in_size;
      err_q  <= 1'b0;
    end else if (desc_take_i) begin
      // arbitration settings only change through a quiescent register write
      done_q <= in_done;
      size_q <= in_size;
      if (arb_differs) err_q <= 1'b1;
    end
  end

  assign cls_o     = cls_q;
  assign wgt_o     = wgt_q;
  assign done_o    = done_q;
  assign size_o    = size_q;
  assign cfg_err_o = err_q;

  assert_arb_kept_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> ($stable(cls_q) && $stable(wgt_q)));
  assert_err_from_desc_R8: assert property (@(posedge clk) disable iff (rst)
    (!err_q && !desc_take_i) |=> !err_q);
endmodule

// File: rtl/dbt_issue_counter.sv
module dbt_issue_counter #(
  parameter int SIZE_W  = 17,
  parameter int ISSUE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [ISSUE_W-1:0] bytes_i,
  input  logic [SIZE_W-1:0]  limit_i,
  output logic [SIZE_W-1:0]  cnt_o,
  output logic               at_limit_o
);
  localparam int SUM_W = SIZE_W + 1;

  logic [SIZE_W-1:0] cnt_q, sat_val;
  logic [SUM_W-1:0]  sum;

  assign sum     = {1'b0, cnt_q} + {{(SUM_W-ISSUE_W){1'b0}}, bytes_i};
  assign sat_val = (sum > {1'b0, limit_i}) ? limit_i : sum[SIZE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= sat_val;
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == limit_i);

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> (cnt_q <= $past(limit_i)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/dbt_seq.sv
module dbt_seq
  import dbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ch_enable_i,
  input  logic       wb_en_i,
  input  logic       sw_wr_req_i,
  input  logic       desc_ld_i,
  input  logic       desc_done_i,
  input  logic       issue_vld_i,
  input  logic       at_limit_i,
  output dbt_state_e state_o,
  output logic       sw_wr_o,
  output logic       desc_take_o,
  output logic       cnt_clr_o,
  output logic       cnt_inc_o,
  output logic       complete_o,
  output logic       blk_done_o,
  output logic       wb_req_o,
  output logic       desc_rej_o
);
  dbt_state_e st_q, st_d;
  logic rej_set, rej_q, done_q, wbr_q;

  always_comb begin
    st_d        = st_q;
    sw_wr_o     = 1'b0;
    desc_take_o = 1'b0;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    complete_o  = 1'b0;
    rej_set     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (sw_wr_req_i && !ch_enable_i) begin
          sw_wr_o = 1'b1;
        end else if (desc_ld_i) begin
          if (desc_done_i) rej_set = 1'b1;
          else             desc_take_o = 1'b1;
        end
        if (rej_set) begin
          st_d = ST_HALT;
        end else if (ch_enable_i) begin
          st_d      = ST_RUN;
          cnt_clr_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (!ch_enable_i) begin
          st_d = ST_IDLE;
        end else if (at_limit_i) begin
          complete_o = 1'b1;
          st_d       = ST_BLKEND;
        end else begin
          cnt_inc_o = issue_vld_i;
        end
      end
      ST_BLKEND: begin
        if (!ch_enable_i) begin
          st_d = ST_IDLE;
        end else if (desc_ld_i) begin
          if (desc_done_i) begin
            rej_set = 1'b1;
            st_d    = ST_HALT;
          end else begin
            desc_take_o = 1'b1;
            cnt_clr_o   = 1'b1;
            st_d        = ST_RUN;
          end
        end
      end
      ST_HALT: begin
        if (sw_wr_req_i && !ch_enable_i) begin
          sw_wr_o = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rej_q  <= 1'b0;
      done_q <= 1'b0;
      wbr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= complete_o;
      wbr_q  <= complete_o && wb_en_i;
      if (rej_set)      rej_q <= 1'b1;
      else if (sw_wr_o) rej_q <= 1'b0;
    end
  end

  assign state_o    = st_q;
  assign blk_done_o = done_q;
  assign wb_req_o   = wbr_q;
  assign desc_rej_o = rej_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    wbr_q |-> done_q);
  assert_halt_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT) |=> (st_q == ST_HALT || st_q == ST_IDLE));
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT) |=> !done_q);
  assert_no_count_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |-> !cnt_inc_o);
endmodule

// File: rtl/dma_blk_tracker.sv
module dma_blk_tracker
  import dbt_pkg::*;
#(
  parameter int CLASS_W  = 3,
  parameter int WEIGHT_W = 11,
  parameter int SIZE_W   = 17,
  parameter int ISSUE_W  = 12,
  localparam int WORD_W  = CLASS_W + WEIGHT_W + 1 + SIZE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ch_enable,
  input  logic               wb_enable,
  input  logic               reg_wr_en,
  input  logic [WORD_W-1:0]  reg_wr_data,
  output logic [WORD_W-1:0]  reg_rd_data,
  input  logic               desc_ld_en,
  input  logic [WORD_W-1:0]  desc_ld_data,
  input  logic               rd_issue_vld,
  input  logic [ISSUE_W-1:0] rd_issue_bytes,
  output logic               blk_done,
  output logic               wb_req,
  output logic [WORD_W-1:0]  wb_data,
  output logic               desc_rej,
  output logic               cfg_err
);
  dbt_state_e          state;
  logic                sw_wr, desc_take, cnt_clr, cnt_inc, complete, at_limit;
  logic [CLASS_W-1:0]  cls;
  logic [WEIGHT_W-1:0] wgt;
  logic                done_flag;
  logic [SIZE_W-1:0]   size, cnt;
  logic [WORD_W-1:0]   cfg_word, rd_q, wb_q;
  logic                show_cnt;

  dbt_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .ch_enable_i (ch_enable),
    .wb_en_i     (wb_enable),
    .sw_wr_req_i (reg_wr_en),
    .desc_ld_i   (desc_ld_en),
    .desc_done_i (desc_ld_data[SIZE_W]),
    .issue_vld_i (rd_issue_vld),
    .at_limit_i  (at_limit),
    .state_o     (state),
    .sw_wr_o     (sw_wr),
    .desc_take_o (desc_take),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .complete_o  (complete),
    .blk_done_o  (blk_done),
    .wb_req_o    (wb_req),
    .desc_rej_o  (desc_rej)
  );

  dbt_cfg_regs #(
    .CLASS_W  (CLASS_W),
    .WEIGHT_W (WEIGHT_W),
    .SIZE_W   (SIZE_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .sw_wr_i     (sw_wr),
    .desc_take_i (desc_take),
    .word_i      (sw_wr ? reg_wr_data : desc_ld_data),
    .cls_o       (cls),
    .wgt_o       (wgt),
    .done_o      (done_flag),
    .size_o      (size),
    .cfg_err_o   (cfg_err)
  );

  dbt_issue_counter #(
    .SIZE_W  (SIZE_W),
    .ISSUE_W (ISSUE_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (cnt_clr),
    .inc_i      (cnt_inc),
    .bytes_i    (rd_issue_bytes),
    .limit_i    (size),
    .cnt_o      (cnt),
    .at_limit_o (at_limit)
  );

  assign show_cnt = (state == ST_RUN) || (state == ST_BLKEND);
  assign cfg_word = {cls, wgt, done_flag, show_cnt ? cnt : size};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      wb_q <= '0;
    end else begin
      rd_q <= cfg_word;
      if (complete) wb_q <= {cls, wgt, 1'b1, size};
    end
  end

  assign reg_rd_data = rd_q;
  assign wb_data     = wb_q;

  assert_wb_flag_R6: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> wb_data[SIZE_W]);
  assert_done_full_R5: assert property (@(posedge clk) disable iff (rst)
    complete |-> (cnt == size));
endmodule

// File: tb/dma_blk_tracker_tb.sv
module dma_blk_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        ch_enable, wb_enable, reg_wr_en, desc_ld_en, rd_issue_vld;
  logic [31:0] reg_wr_data, desc_ld_data, reg_rd_data, wb_data;
  logic [11:0] rd_issue_bytes;
  logic        blk_done, wb_req, desc_rej, cfg_err;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_blk_tracker u_dut (
    .clk(clk), .rst(rst), .ch_enable(ch_enable), .wb_enable(wb_enable),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .desc_ld_en(desc_ld_en), .desc_ld_data(desc_ld_data),
    .rd_issue_vld(rd_issue_vld), .rd_issue_bytes(rd_issue_bytes),
    .blk_done(blk_done), .wb_req(wb_req), .wb_data(wb_data),
    .desc_rej(desc_rej), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] mk(int cls, int wgt, int dn, int size);
    return {cls[2:0], wgt[10:0], dn[0], size[16:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_write(logic [31:0] w);
    reg_wr_en = 1'b1; reg_wr_data = w; step(); reg_wr_en = 1'b0; step();
  endtask

  task automatic issue(int b);
    rd_issue_vld = 1'b1; rd_issue_bytes = b[11:0]; step();
    rd_issue_vld = 1'b0; step();
  endtask

  // runs the current block to completion, checking the count and the pulses
  task automatic run_block(int cls, int wgt, int dn, int size, bit wbe);
    int exp_cnt = 0;
    for (int i = 0; i < 400 && exp_cnt < size; i++) begin
      int b = $urandom_range(1, 64);
      issue(b);
      exp_cnt = (exp_cnt + b > size) ? size : exp_cnt + b;
      chk("R3 running count", reg_rd_data, mk(cls, wgt, dn, exp_cnt));
      chk("R5 done at size", {31'd0, blk_done}, {31'd0, exp_cnt == size});
      if (exp_cnt == size) begin
        chk("R6 wb req", {31'd0, wb_req}, {31'd0, wbe});
        if (wbe) chk("R6 wb word", wb_data, mk(cls, wgt, 1, size));
      end
    end
    step();
    chk("R5 pulse drops", {31'd0, blk_done}, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; ch_enable = 1'b0; wb_enable = 1'b0; reg_wr_en = 1'b0;
    desc_ld_en = 1'b0; rd_issue_vld = 1'b0; reg_wr_data = '0;
    desc_ld_data = '0; rd_issue_bytes = '0;
    repeat (3) step();
    rst = 1'b0; step();
    chk("R1 rd reset", reg_rd_data, 32'd0);
    chk("R1 flags reset", {28'd0, blk_done, wb_req, desc_rej, cfg_err}, 32'd0);

    sw_write(mk(2, 5, 0, 100));
    chk("R2 write load", reg_rd_data, mk(2, 5, 0, 100));

    wb_enable = 1'b1; ch_enable = 1'b1; step(); step();
    chk("R3 start count", reg_rd_data, mk(2, 5, 0, 0));
    run_block(2, 5, 0, 100, 1'b1);

    issue(7);
    chk("R10 no count at end", reg_rd_data, mk(2, 5, 0, 100));
    chk("R10 no done", {31'd0, blk_done}, 32'd0);

    sw_write(mk(6, 9, 0, 3));
    chk("R2 write ignored enabled", reg_rd_data, mk(2, 5, 0, 100));

    desc_ld_en = 1'b1; desc_ld_data = mk(2, 5, 0, 'h30); step();
    desc_ld_en = 1'b0; step();
    chk("R9 new block cleared", reg_rd_data, mk(2, 5, 0, 0));
    chk("R8 no err on match", {31'd0, cfg_err}, 32'd0);
    issue('h50);
    chk("R3 saturate", reg_rd_data, mk(2, 5, 0, 'h30));
    chk("R5 done sat", {31'd0, blk_done}, 32'd1);
    chk("R6 wb word sat", wb_data, mk(2, 5, 1, 'h30));

    wb_enable = 1'b0;
    desc_ld_en = 1'b1; desc_ld_data = mk(5, 5, 0, 'h10); step();
    desc_ld_en = 1'b0; step();
    chk("R8 cfg err", {31'd0, cfg_err}, 32'd1);
    chk("R8 class kept", reg_rd_data, mk(2, 5, 0, 0));
    issue('h10);
    chk("R5 done", {31'd0, blk_done}, 32'd1);
    chk("R6 no wb when off", {31'd0, wb_req}, 32'd0);

    desc_ld_en = 1'b1; desc_ld_data = mk(2, 5, 1, 'h40); step();
    desc_ld_en = 1'b0; step();
    chk("R7 rej flag", {31'd0, desc_rej}, 32'd1);
    chk("R7 not loaded", reg_rd_data, mk(2, 5, 0, 'h10));
    issue(4); issue(4);
    chk("R7 halted no done", {31'd0, blk_done}, 32'd0);
    chk("R7 halted rd", reg_rd_data, mk(2, 5, 0, 'h10));

    ch_enable = 1'b0; step(); step();
    chk("R4 disabled size", reg_rd_data, mk(2, 5, 0, 'h10));
    issue(9);
    chk("R10 idle no count", reg_rd_data, mk(2, 5, 0, 'h10));

    sw_write(mk(1, 'h7FF, 0, 0));
    chk("R2 halt cleared", {30'd0, desc_rej, cfg_err}, 32'd0);
    chk("R2 zero size load", reg_rd_data, mk(1, 'h7FF, 0, 0));
    wb_enable = 1'b1; ch_enable = 1'b1; step();
    chk("R5 zero not yet", {31'd0, blk_done}, 32'd0);
    step();
    chk("R5 zero size done", {31'd0, blk_done}, 32'd1);
    chk("R6 zero wb", wb_data, mk(1, 'h7FF, 1, 0));

    for (int r = 0; r < 20; r++) begin
      int cls = $urandom_range(0, 7);
      int wgt = $urandom_range(0, 2047);
      int dn  = $urandom_range(0, 1);
      int sz  = $urandom_range(1, 300);
      bit wbe = 1'($urandom_range(0, 1));
      ch_enable = 1'b0; step(); step();
      sw_write(mk(cls, wgt, dn, sz));
      chk("R4 random size", reg_rd_data, mk(cls, wgt, dn, sz));
      wb_enable = wbe; ch_enable = 1'b1; step(); step();
      run_block(cls, wgt, dn, sz, wbe);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule